// File: doc/BRIEF.md
# Two-Source Subword Permutation Unit

This block is a single-cycle permutation stage for a 64-bit packed-subword datapath. It accepts two source words, an operation code and a subword width, and produces one rearranged word. The five operations are fixed patterns: even/odd interleave, odd/odd interleave, checkerboard merge, pair swap, and a checkerboard merge followed by a pair swap. Together they are enough to reach every reordering of a 2x2 pixel block that is stored in two registers, one row per register.

The result and a valid flag are registered, so the answer for an operation presented in cycle N appears after the clock edge that ends cycle N. Subword positions are counted from the most significant end. Position 0 is the leftmost subword.

Top module: `subword_permute_unit`

## Requirements
- R1: With op=0 (even interleave), result position 2j takes src_a position 2j and result position 2j+1 takes src_b position 2j. Position 0 is bits [63:56], [63:48] or [63:32] for size codes 0, 1 and 2 (8, 16 and 32 bits).
- R2: With op=1 (odd interleave), result position 2j takes src_a position 2j+1 and result position 2j+1 takes src_b position 2j+1, at all three sizes.
- R3: With op=2 (checkerboard), even result positions come from src_a and odd result positions come from src_b, each at the same position.
- R4: With op=3 (pair swap), result position p takes src_a position p XOR 1. src_b has no effect on the result.
- R5: With op=4 (swapped checkerboard), result position p takes the checkerboard value of position p XOR 1. That value is src_a when p XOR 1 is even and src_b when it is odd.
- R6: Exchanging src_a and src_b changes the result of ops 0, 1, 2 and 4 as R1-style rules predict for the new order. Both orders are served with no restriction.
- R7: out_valid equals in_valid of the previous cycle. result carries the outcome of the inputs from that same previous cycle.
- R8: When in_valid is low, result keeps its previous value whatever the other inputs are.
- R9: An op code of 5 to 7, or a size code of 3, gives result equal to src_a.
- R10: While rst_n is low, out_valid is 0 and result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code: 0 even interleave, 1 odd interleave, 2 checkerboard, 3 pair swap, 4 swapped checkerboard |
| size | input | 2 | Subword width: 0 = 8, 1 = 16, 2 = 32 bits |
| src_a | input | 64 | First source word |
| src_b | input | 64 | Second source word (not used by pair swap) |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered permuted word |

## Verification
Every op and size pair is driven with a distinctive pattern, then with the two sources swapped, and then with random words. A unit that mixed up the even and odd lanes, or the left and right ends, would give one interleave in place of the other or a mirror image. The pair swap is run with a changing src_b, which catches a unit that wrongly reads the second source. Idle cycles carry garbage inputs to check that the result holds. Unused op and size codes are driven to check that a wrong decode does not produce a permutation in place of src_a.

// File: rtl/spu_pkg.sv
package spu_pkg;
    localparam int SPU_OP_W   = 3;
    localparam int SPU_SIZE_W = 2;
    localparam int SPU_LEVELS = 3;

    typedef enum logic [SPU_OP_W-1:0] {
        OP_MIX_EVEN   = 3'd0,
        OP_MIX_ODD    = 3'd1,
        OP_CHECKER    = 3'd2,
        OP_PAIR_SWAP  = 3'd3,
        OP_SWAP_CHECK = 3'd4
    } spu_op_e;

    typedef enum logic [SPU_SIZE_W-1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2
    } spu_size_e;
endpackage

// File: rtl/spu_mix.sv
module spu_mix #(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              odd_sel,
    output logic [DATA_W-1:0] y
);
    localparam int NSUB  = DATA_W / SUB_W;
    localparam int PAIRS = NSUB / 2;

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        localparam int HI_E = DATA_W - 1 - (2 * j) * SUB_W;
        localparam int HI_O = DATA_W - 1 - (2 * j + 1) * SUB_W;
        assign y[HI_E -: SUB_W] = odd_sel ? a[HI_O -: SUB_W] : a[HI_E -: SUB_W];
        assign y[HI_O -: SUB_W] = odd_sel ? b[HI_O -: SUB_W] : b[HI_E -: SUB_W];
    end
endmodule

// File: rtl/spu_checker_merge.sv
module spu_checker_merge #(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int NSUB = DATA_W / SUB_W;

    for (genvar p = 0; p < NSUB; p++) begin : g_pos
        localparam int HI = DATA_W - 1 - p * SUB_W;
        if (p % 2 == 0) begin : g_even
            assign y[HI -: SUB_W] = a[HI -: SUB_W];
        end else begin : g_odd
            assign y[HI -: SUB_W] = b[HI -: SUB_W];
        end
    end
endmodule

// File: rtl/spu_pair_swap.sv
module spu_pair_swap #(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 8
) (
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] y
);
    localparam int NSUB = DATA_W / SUB_W;

    for (genvar p = 0; p < NSUB; p++) begin : g_pos
        localparam int HI_DST = DATA_W - 1 - p * SUB_W;
        localparam int HI_SRC = DATA_W - 1 - (p ^ 1) * SUB_W;
        assign y[HI_DST -: SUB_W] = a[HI_SRC -: SUB_W];
    end
endmodule

// File: rtl/subword_permute_unit.sv
module subword_permute_unit #(
    parameter int DATA_W    = 64,
    parameter int MIN_SUB_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [spu_pkg::SPU_OP_W-1:0]    op,
    input  logic [spu_pkg::SPU_SIZE_W-1:0]  size,
    input  logic [DATA_W-1:0]               src_a,
    input  logic [DATA_W-1:0]               src_b,
    output logic                            out_valid,
    output logic [DATA_W-1:0]               result
);
    import spu_pkg::*;

    localparam int LEVELS = SPU_LEVELS;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [DATA_W-1:0] mix_res   [LEVELS];
    logic [DATA_W-1:0] check_res [LEVELS];
    logic [DATA_W-1:0] swap_res  [LEVELS];
    logic [DATA_W-1:0] xchk_res  [LEVELS];
    logic              odd_sel;

    assign odd_sel = (op == OP_MIX_ODD);

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        localparam int SUB_W = MIN_SUB_W << k;

        spu_mix #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_mix (
            .a(src_a), .b(src_b), .odd_sel(odd_sel), .y(mix_res[k])
        );
        spu_checker_merge #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_check (
            .a(src_a), .b(src_b), .y(check_res[k])
        );
        spu_pair_swap #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_swap (
            .a(src_a), .y(swap_res[k])
        );
        spu_pair_swap #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_xchk (
            .a(check_res[k]), .y(xchk_res[k])
        );
    end

    always_comb begin
        spu_op_e   op_e;
        spu_size_e sz_e;
        logic      sz_ok;
        op_e    = spu_op_e'(op);
        sz_e    = spu_size_e'(size);
        sz_ok   = (sz_e == SZ_8) || (sz_e == SZ_16) || (sz_e == SZ_32);
        stage_d = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = src_a;
            if (sz_ok) begin
                case (op_e)
                    OP_MIX_EVEN,
                    OP_MIX_ODD:    stage_d.res = mix_res[size];
                    OP_CHECKER:    stage_d.res = check_res[size];
                    OP_PAIR_SWAP:  stage_d.res = swap_res[size];
                    OP_SWAP_CHECK: stage_d.res = xchk_res[size];
                    default:       stage_d.res = src_a;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
endmodule

// File: rtl/spu_checker.sv
module spu_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    localparam int HALF = DATA_W / 2;

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && result == '0));

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_even_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && size == 2'd2) |=>
        result == {$past(src_a[DATA_W-1 -: HALF]), $past(src_b[DATA_W-1 -: HALF])});

    p_odd_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd1 && size == 2'd2) |=>
        result == {$past(src_a[HALF-1:0]), $past(src_b[HALF-1:0])});

    p_checker_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2 && size == 2'd2) |=>
        result == {$past(src_a[DATA_W-1 -: HALF]), $past(src_b[HALF-1:0])});

    p_swap_popcount_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3 && size != 2'd3) |=>
        $countones(result) == $countones($past(src_a)));

    p_passthrough_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op > 3'd4 || size == 2'd3)) |=> result == $past(src_a));
endmodule

bind subword_permute_unit spu_checker #(.DATA_W(DATA_W)) u_spu_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
);

// File: tb/subword_permute_unit_tb_top.sv
module subword_permute_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    logic        exp_v = 1'b0;
    logic [63:0] exp_r = '0;
    string       exp_tag = "R10";

    always #10 clk = ~clk;

    subword_permute_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] get_sub(logic [63:0] x, int w, int idx);
        logic [63:0] m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        return (x >> (64 - (idx + 1) * w)) & m;
    endfunction

    function automatic logic [63:0] model(int o, int s, logic [63:0] a, logic [63:0] b);
        int w, n, idx;
        logic [63:0] r, pick;
        bit from_b;
        if (o > 4 || s > 2) return a;
        w = 8 << s;
        n = 64 / w;
        r = '0;
        for (int p = 0; p < n; p++) begin
            case (o)
                0: begin from_b = (p % 2) == 1; idx = (p / 2) * 2; end
                1: begin from_b = (p % 2) == 1; idx = (p / 2) * 2 + 1; end
                2: begin from_b = (p % 2) == 1; idx = p; end
                3: begin from_b = 1'b0; idx = p ^ 1; end
                default: begin idx = p ^ 1; from_b = (idx % 2) == 1; end
            endcase
            pick = from_b ? get_sub(b, w, idx) : get_sub(a, w, idx);
            r = (r << w) | pick;
        end
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || result !== exp_r) begin
            fails++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     exp_tag, out_valid, result, exp_v, exp_r);
        end
    endtask

    task automatic step(input bit v, input int o, input int s,
                        input logic [63:0] a, input logic [63:0] b, input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        op       = 3'(o);
        size     = 2'(s);
        src_a    = a;
        src_b    = b;
        if (v) exp_r = model(o, s, a, b);
        exp_v   = v;
        exp_tag = tag;
    endtask

    function automatic string op_tag(int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: expired, expected run to complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] pa, pb, ra, rb;
        pa = 64'h0011223344556677;
        pb = 64'h8899AABBCCDDEEFF;
        repeat (3) @(negedge clk);
        compare();                      // R10 during reset
        rst_n = 1'b1;
        step(1'b0, 0, 0, '0, '0, "R10");

        for (int o = 0; o < 5; o++)
            for (int s = 0; s < 3; s++) begin
                step(1'b1, o, s, pa, pb, op_tag(o));
                step(1'b1, o, s, pb, pa, (o == 3) ? "R4" : "R6");
            end

        for (int i = 0; i < 8; i++)                       // R4 src_b has no effect
            step(1'b1, 3, i % 3, pa, {$urandom, $urandom}, "R4");

        step(1'b1, 2, 0, pa, pb, "R7");
        step(1'b0, 1, 1, pb, pa, "R8");
        step(1'b0, 4, 2, {$urandom, $urandom}, {$urandom, $urandom}, "R8");
        step(1'b1, 0, 0, pb, pa, "R7");
        step(1'b0, 3, 0, pa, pa, "R7");

        for (int o = 5; o < 8; o++) step(1'b1, o, 0, pa, pb, "R9");
        for (int o = 0; o < 5; o++) step(1'b1, o, 3, pb, pa, "R9");

        for (int i = 0; i < 300; i++) begin
            int o, s;
            o  = i % 5;
            s  = (i / 5) % 3;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            step(1'b1, o, s, ra, rb, op_tag(o));
            step((i % 7) != 0, o, s, rb, ra, "R6");
        end

        step(1'b0, 0, 0, '0, '0, "R7");
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule